// File: doc/BRIEF.md
# Shared-Control Add/Subtract and Logic ALU

This block is an arithmetic logic unit with two operand buses, one operation bit and one unit-select bit. The arithmetic side is a ripple chain of one-bit full adders. Every B bit passes through an XOR gate driven by the operation bit, and the same bit feeds the carry into the lowest stage. Operation bit 0 therefore gives A + B, and operation bit 1 gives A plus the inverse of B plus one, which is A − B. The logic side uses the same operation bit to choose between a bitwise AND and a bitwise OR.

A multiplexer driven by the unit-select bit places one of the two results on the output bus. The arithmetic side also reports the raw carry out of the top stage and a signed overflow flag. The overflow flag is the carry into the top stage XOR the carry out of it. The outputs are held in an optional output register, which is present by default and gives one cycle of latency.

There is no sequencing state. The only storage is the output register, which has two conditions: held clear while reset is low, and loading every cycle otherwise.

Top module: `shared_ctl_alu`

## Requirements
- R1: While `rst_n` is sampled low at a rising clock edge, `result`, `carry_out` and `ovf_out` are all 0 after that edge.
- R2: With `unit_sel`=1 and `op_sel`=0, `result` is (opa + opb) mod 2^W, and `carry_out` is bit W of the unsigned sum.
- R3: With `unit_sel`=0 and `op_sel`=0, `result` is opa AND opb, bit by bit.
- R4: With `unit_sel`=0 and `op_sel`=1, `result` is opa OR opb, bit by bit.
- R5: With `unit_sel`=1 and `op_sel`=1, `result` is (opa − opb) mod 2^W, and `carry_out` is 1 exactly when opa ≥ opb as unsigned numbers (1 means no borrow).
- R6: With `unit_sel`=1, `ovf_out` is 1 exactly when the two's-complement result of the selected add or subtract lies outside the signed W-bit range.
- R7: With `unit_sel`=0, `carry_out` and `ovf_out` are 0.
- R8: With the default `REG_OUT`=1, the outputs reflect the inputs sampled at the previous rising edge and do not change between edges. With `REG_OUT`=0 the outputs are purely combinational.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Synchronous active-low reset |
| opa | input | W | Operand A |
| opb | input | W | Operand B |
| op_sel | input | 1 | 0: AND / add, 1: OR / subtract |
| unit_sel | input | 1 | 0: logic unit, 1: arithmetic unit |
| result | output | W | Selected unit's result |
| carry_out | output | 1 | Carry from the top adder stage (0 for the logic unit) |
| ovf_out | output | 1 | Signed overflow (0 for the logic unit) |

## Verification
On every cycle, the assertions compare the registered result and flags for all four operation/unit combinations against wide-arithmetic and bitwise expressions of the previous cycle's operands. They also check that reset clears the outputs and that the logic unit reports no flags. Some behaviour only the bench's scenarios can show. The one-cycle latency is checked by sampling between edges. The bench also steers the add/subtract operand corners on purpose: zero, all-ones and the most negative value, on both sides of the borrow boundary and at both signed overflow limits. A reset asserted in the middle of a run is also a bench scenario.

// File: rtl/shared_alu_pkg.sv
package shared_alu_pkg;
    typedef enum logic {
        UNIT_LOGIC = 1'b0,
        UNIT_ARITH = 1'b1
    } unit_e;

    typedef enum logic {
        OP_AND_ADD = 1'b0,
        OP_OR_SUB  = 1'b1
    } op_e;
endpackage

// File: rtl/fa_cell.sv
module fa_cell (
    input  logic a,
    input  logic b,
    input  logic ci,
    output logic s,
    output logic co
);
    logic p;
    assign p  = a ^ b;
    assign s  = p ^ ci;
    assign co = (a & b) | (p & ci);
endmodule

// File: rtl/ripple_addsub.sv
module ripple_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    logic [W:0]   chain;
    logic [W-1:0] b_eff;

    // the operation bit supplies the +1 of two's complement
    assign chain[0] = sub;

    for (genvar i = 0; i < W; i++) begin : g_stage
        assign b_eff[i] = b[i] ^ sub;
        fa_cell u_fa (
            .a  (a[i]),
            .b  (b_eff[i]),
            .ci (chain[i]),
            .s  (sum[i]),
            .co (chain[i+1])
        );
    end

    assign cout = chain[W];
    assign ovf  = chain[W] ^ chain[W-1];
endmodule

// File: rtl/bitwise_unit.sv
module bitwise_unit #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         use_or,
    output logic [W-1:0] y
);
    logic [W-1:0] and_v;
    logic [W-1:0] or_v;

    assign and_v = a & b;
    assign or_v  = a | b;
    assign y     = use_or ? or_v : and_v;
endmodule

// File: rtl/shared_ctl_alu.sv
module shared_ctl_alu
    import shared_alu_pkg::*;
#(
    parameter int W       = 32,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         op_sel,
    input  logic         unit_sel,
    output logic [W-1:0] result,
    output logic         carry_out,
    output logic         ovf_out
);
    logic [W-1:0] arith_y;
    logic         arith_c;
    logic         arith_v;
    logic [W-1:0] logic_y;

    logic [W-1:0] mux_y;
    logic         mux_c;
    logic         mux_v;

    ripple_addsub #(.W(W)) u_arith (
        .a    (opa),
        .b    (opb),
        .sub  (op_sel),
        .sum  (arith_y),
        .cout (arith_c),
        .ovf  (arith_v)
    );

    bitwise_unit #(.W(W)) u_logic (
        .a      (opa),
        .b      (opb),
        .use_or (op_sel),
        .y      (logic_y)
    );

    // output selector
    always_comb begin
        unique case (unit_e'(unit_sel))
            UNIT_ARITH: begin
                mux_y = arith_y;
                mux_c = arith_c;
                mux_v = arith_v;
            end
            default: begin
                mux_y = logic_y;
                mux_c = 1'b0;
                mux_v = 1'b0;
            end
        endcase
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                result    <= '0;
                carry_out <= 1'b0;
                ovf_out   <= 1'b0;
            end else begin
                result    <= mux_y;
                carry_out <= mux_c;
                ovf_out   <= mux_v;
            end
        end
    end else begin : g_comb
        assign result    = mux_y;
        assign carry_out = mux_c;
        assign ovf_out   = mux_v;
    end
endmodule

// File: rtl/shared_ctl_alu_chk.sv
module shared_ctl_alu_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] opa,
    input logic [W-1:0] opb,
    input logic         op_sel,
    input logic         unit_sel,
    input logic [W-1:0] result,
    input logic         carry_out,
    input logic         ovf_out
);
    logic [W:0] add_ref;
    logic [W:0] sub_ref;
    logic       add_v;
    logic       sub_v;

    assign add_ref = {1'b0, opa} + {1'b0, opb};
    assign sub_ref = {1'b0, opa} + {1'b0, ~opb} + {{W{1'b0}}, 1'b1};
    assign add_v   = (opa[W-1] == opb[W-1]) && (add_ref[W-1] != opa[W-1]);
    assign sub_v   = (opa[W-1] != opb[W-1]) && (sub_ref[W-1] != opa[W-1]);

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (result == '0 && !carry_out && !ovf_out));

    p_add_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_sel && !op_sel) |=> ({carry_out, result} == $past(add_ref)));

    p_and_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!unit_sel && !op_sel) |=> (result == $past(opa & opb)));

    p_or_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!unit_sel && op_sel) |=> (result == $past(opa | opb)));

    p_sub_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_sel && op_sel) |=> ({carry_out, result} == $past(sub_ref)));

    p_ovf_add_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_sel && !op_sel) |=> (ovf_out == $past(add_v)));

    p_ovf_sub_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_sel && op_sel) |=> (ovf_out == $past(sub_v)));

    p_no_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !unit_sel |=> (!carry_out && !ovf_out));
endmodule

bind shared_ctl_alu shared_ctl_alu_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .opa       (opa),
    .opb       (opb),
    .op_sel    (op_sel),
    .unit_sel  (unit_sel),
    .result    (result),
    .carry_out (carry_out),
    .ovf_out   (ovf_out)
);

// File: tb/sim_shared_ctl_alu.sv
`timescale 1ns/1ps
module sim_shared_ctl_alu;
    localparam int W = 32;

    typedef struct {
        logic [W-1:0] r;
        logic         c;
        logic         v;
        logic         u;
        logic         o;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;
    logic         op_sel = 1'b0;
    logic         unit_sel = 1'b0;
    logic [W-1:0] result;
    logic         carry_out;
    logic         ovf_out;

    int checks = 0;
    int errors = 0;
    exp_t pend[$];
    logic [W-1:0] last_r;

    always #2.5 clk = ~clk;

    shared_ctl_alu #(.W(W)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .opa       (opa),
        .opb       (opb),
        .op_sel    (op_sel),
        .unit_sel  (unit_sel),
        .result    (result),
        .carry_out (carry_out),
        .ovf_out   (ovf_out)
    );

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic exp_t model(logic [W-1:0] a, logic [W-1:0] b, logic o, logic u);
        exp_t e;
        longint sa, sb, sr;
        logic [63:0] wide;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        e.u = u;
        e.o = o;
        if (!u) begin
            e.r = o ? (a | b) : (a & b);
            e.c = 1'b0;
            e.v = 1'b0;
        end else begin
            if (!o) begin
                wide = {32'd0, a} + {32'd0, b};
                e.c  = wide[W];
                sr   = sa + sb;
            end else begin
                e.c  = (a >= b);
                wide = {32'd0, a} - {32'd0, b};
                sr   = sa - sb;
            end
            e.r = wide[W-1:0];
            e.v = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
        end
        return e;
    endfunction

    // one clock: drive at falling edge, compare the previous vector's result
    task automatic step(logic [W-1:0] a, logic [W-1:0] b, logic o, logic u);
        @(negedge clk);
        if (pend.size() > 0) begin
            exp_t e;
            e = pend.pop_front();
            if (!e.u)
                chk(e.o ? "R4 or" : "R3 and", result, e.r);
            else
                chk(e.o ? "R5 sub" : "R2 add", result, e.r);
            chk(e.u ? (e.o ? "R5 carry" : "R2 carry") : "R7 carry", {31'd0, carry_out}, {31'd0, e.c});
            chk(e.u ? "R6 ovf" : "R7 ovf", {31'd0, ovf_out}, {31'd0, e.v});
            last_r = e.r;
        end
        opa = a; opb = b; op_sel = o; unit_sel = u;
        pend.push_back(model(a, b, o, u));
    endtask

    task automatic all_ops(logic [W-1:0] a, logic [W-1:0] b);
        for (int k = 0; k < 4; k++) step(a, b, k[0], k[1]);
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual running expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] corners [5];
        corners[0] = 32'h0000_0000;
        corners[1] = 32'hFFFF_FFFF;
        corners[2] = 32'h8000_0000;
        corners[3] = 32'h7FFF_FFFF;
        corners[4] = 32'h0000_0001;

        // R1: outputs cleared during reset even with live operands
        opa = 32'hDEAD_BEEF; opb = 32'h1234_5678; unit_sel = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 reset result", result, '0);
        chk("R1 reset flags", {30'd0, carry_out, ovf_out}, '0);
        rst_n = 1'b1;

        foreach (corners[i])
            foreach (corners[j])
                all_ops(corners[i], corners[j]);

        // borrow boundary and signed limits
        all_ops(32'd5, 32'd5);
        all_ops(32'd4, 32'd5);
        all_ops(32'h7FFF_FFFF, 32'hFFFF_FFFF);
        all_ops(32'h8000_0000, 32'h0000_0001);

        for (int n = 0; n < 400; n++)
            step($urandom, $urandom, n[0], n[1] ^ n[3]);

        // R8: registered output holds between edges
        step(32'h0000_000F, 32'h0000_00F0, 1'b1, 1'b0);
        step(32'hAAAA_0000, 32'h0000_5555, 1'b1, 1'b1);
        #1;
        chk("R8 hold between edges", result, last_r);
        @(posedge clk); #1;
        chk("R8 one-cycle latency", result, 32'hAAAA_0000 - 32'h0000_5555);

        // R1: reset asserted mid-run
        @(negedge clk);
        pend.delete();
        rst_n = 1'b0;
        opa = 32'hFFFF_FFFF; opb = 32'h1; op_sel = 1'b0; unit_sel = 1'b1;
        @(negedge clk);
        chk("R1 mid-run reset result", result, '0);
        chk("R1 mid-run reset carry", {31'd0, carry_out}, '0);
        rst_n = 1'b1;
        step(32'd9, 32'd3, 1'b1, 1'b1);
        step(32'd0, 32'd0, 1'b0, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule